// File: doc/BRIEF.md
# Packed SIMD Rounding Shifter

This block shifts a 32-bit operand in one of three lane layouts: one signed 32-bit word, two 16-bit halves, or four 8-bit bytes. Every lane is shifted by the same amount and independently of its neighbours, so no bit ever moves from one lane into the next. The operation can be a plain left shift, a left shift that clamps to the lane's signed range, an arithmetic right shift, an arithmetic right shift that rounds half up, or a logical right shift. Which operations are allowed depends on the lane width.

The shift amount comes from a 5-bit immediate field or from the low bits of a 32-bit register operand, chosen by a select input. Each accepted request produces one registered result a cycle later, together with an output valid strobe. A sticky overflow flag records every lane saturation since reset.

Top module: `simd_shift_unit`

## Requirements
- R1: A request accepted with `in_valid` high appears on `out_data` with `out_valid` high exactly one clock later. In a cycle with no accepted request, `out_valid` is low on the next clock and `out_data` keeps its value.
- R2: If `in_use_reg` is 1, the amount is `in_amt_reg[4:0]`. If it is 0, the amount is `in_amt_imm`. Word lanes use amount bits [4:0], half lanes use bits [3:0] and byte lanes use bits [2:0]. Higher bits are ignored.
- R3: Operation 0 (plain left shift) is allowed in lane modes 0 (word), 1 (half) and 2 (byte). It shifts each lane left and fills with zeros.
- R4: Operation 1 (saturating left shift) is allowed in word and half modes. If any bit shifted out, or the new sign bit, differs from the lane's original sign bit, the lane is set to its signed maximum (non-negative input) or signed minimum (negative input).
- R5: Operation 2 (arithmetic right shift) is allowed in word and half modes. It fills each lane from the top with copies of the lane's sign bit.
- R6: Operation 3 (rounding arithmetic right shift) is allowed in word and half modes. For an amount n greater than 0 it adds 2^(n-1) to the sign-extended lane in one extra bit and then shifts right arithmetically. For n = 0 the lane is unchanged. The result is never clamped.
- R7: Operation 4 (logical right shift) is allowed only in byte mode. It fills each byte from the top with zeros.
- R8: Lanes are independent. A bit is never carried or shifted from one lane into another lane.
- R9: A combination that is not allowed returns 0 and never sets overflow. This covers any operation code above 4, lane mode 3, operation 4 outside byte mode, and operations 1 to 3 in byte mode.
- R10: `out_ovf` becomes 1 in the result cycle of any request in which a lane saturates. It then stays 1 until reset.
- R11: During and right after reset, `out_valid`, `out_data` and `out_ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_opnd | input | 32 | Operand to shift |
| in_lane | input | 2 | Lane mode: 0 word, 1 half, 2 byte |
| in_op | input | 3 | Operation: 0 shl, 1 saturating shl, 2 sra, 3 rounding sra, 4 srl |
| in_amt_imm | input | 5 | Immediate shift amount |
| in_amt_reg | input | 32 | Register shift amount (only the low bits are used) |
| in_use_reg | input | 1 | 1 selects the register amount |
| out_valid | output | 1 | Result strobe |
| out_data | output | 32 | Shifted result |
| out_ovf | output | 1 | Sticky saturation flag |

## Verification
The first stimulus is a set of directed operands. All-ones bytes and halves with a top bit set show whether any bit leaks across a lane boundary. Odd and negative values shifted right by one show whether rounding goes half up and whether sign extension happens. A maximum half shifted by 15 exercises the extra rounding bit. Register amounts with junk in the upper bits, and byte amounts of 8 or more, test that only the low amount bits are used. Saturating shifts that just fit and just fail mark the exact point where clamping starts. Illegal pairs check that the output is zeroed. A long random run then covers every mode, operation and amount source against an arithmetic model written with integer shifts.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;

    localparam int DATA_W = 32;
    localparam int AMT_W  = $clog2(DATA_W);
    localparam int HALF_W = DATA_W / 2;
    localparam int BYTE_W = 8;
    localparam int N_HALF = DATA_W / HALF_W;
    localparam int N_BYTE = DATA_W / BYTE_W;

    typedef enum logic [1:0] {
        LANE_W32 = 2'd0,
        LANE_H16 = 2'd1,
        LANE_B8  = 2'd2
    } lane_mode_e;

    typedef enum logic [2:0] {
        SH_LEFT   = 3'd0,
        SH_LEFT_S = 3'd1,
        SH_RARITH = 3'd2,
        SH_RROUND = 3'd3,
        SH_RLOGIC = 3'd4
    } shift_op_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              ovf;
    } shift_state_t;

    // Which operation is permitted for a given lane width
    function automatic logic form_ok(input logic [1:0] lane, input logic [2:0] op);
        logic ok;
        ok = 1'b0;
        case (lane)
            LANE_W32, LANE_H16: ok = (op <= 3'(SH_RROUND));
            LANE_B8:            ok = (op == 3'(SH_LEFT)) || (op == 3'(SH_RLOGIC));
            default:            ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/amount_select.sv
module amount_select #(
    parameter int AW = 5
) (
    input  logic          use_reg,
    input  logic [AW-1:0] imm_amt,
    input  logic [AW-1:0] reg_amt,
    output logic [AW-1:0] amt
);
    always_comb begin
        amt = use_reg ? reg_amt : imm_amt;
    end
endmodule

// File: rtl/shift_lane.sv
module shift_lane
    import simd_shift_pkg::*;
#(
    parameter  int W  = 8,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [2:0]    op,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout,
    output logic          sat
);
    logic [W-1:0]        shl;
    logic signed [W-1:0] shl_s;
    logic signed [W-1:0] back;
    logic signed [W:0]   ext;
    logic signed [W:0]   half;
    logic signed [W:0]   rnd;
    logic signed [W:0]   rsh;
    logic                lost;

    always_comb begin
        shl   = din << amt;
        shl_s = shl;
        back  = shl_s >>> amt;
        lost  = (back != din);
        ext   = {din[W-1], din};
        half  = ({{W{1'b0}}, 1'b1} << amt) >> 1;
        rnd   = ext + half;
        rsh   = rnd >>> amt;
        sat   = 1'b0;
        dout  = '0;
        case (op)
            3'(SH_LEFT):   dout = shl;
            3'(SH_LEFT_S): begin
                if (lost) begin
                    sat  = 1'b1;
                    dout = din[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
                end else begin
                    dout = shl;
                end
            end
            3'(SH_RARITH): dout = $signed(din) >>> amt;
            3'(SH_RROUND): dout = rsh[W-1:0];
            3'(SH_RLOGIC): dout = din >> amt;
            default:       dout = '0;
        endcase
    end
endmodule

// File: rtl/simd_shift_unit.sv
module simd_shift_unit
    import simd_shift_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_opnd,
    input  logic [1:0]  in_lane,
    input  logic [2:0]  in_op,
    input  logic [4:0]  in_amt_imm,
    input  logic [31:0] in_amt_reg,
    input  logic        in_use_reg,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic        out_ovf
);
    logic [AMT_W-1:0]  amt_eff;
    logic [DATA_W-1:0] w_res, h_res, b_res;
    logic              w_sat;
    logic [N_HALF-1:0] h_sat;
    logic [N_BYTE-1:0] b_sat;
    logic              unused_amt_hi;
    shift_state_t      st_d, st_q;

    assign unused_amt_hi = ^in_amt_reg[DATA_W-1:AMT_W];

    amount_select #(.AW(AMT_W)) u_amt (
        .use_reg (in_use_reg),
        .imm_amt (in_amt_imm),
        .reg_amt (in_amt_reg[AMT_W-1:0]),
        .amt     (amt_eff)
    );

    shift_lane #(.W(DATA_W)) u_word (
        .din  (in_opnd),
        .op   (in_op),
        .amt  (amt_eff),
        .dout (w_res),
        .sat  (w_sat)
    );

    for (genvar i = 0; i < N_HALF; i++) begin : g_half
        shift_lane #(.W(HALF_W)) u_lane (
            .din  (in_opnd[i*HALF_W +: HALF_W]),
            .op   (in_op),
            .amt  (amt_eff[$clog2(HALF_W)-1:0]),
            .dout (h_res[i*HALF_W +: HALF_W]),
            .sat  (h_sat[i])
        );
    end

    for (genvar i = 0; i < N_BYTE; i++) begin : g_byte
        shift_lane #(.W(BYTE_W)) u_lane (
            .din  (in_opnd[i*BYTE_W +: BYTE_W]),
            .op   (in_op),
            .amt  (amt_eff[$clog2(BYTE_W)-1:0]),
            .dout (b_res[i*BYTE_W +: BYTE_W]),
            .sat  (b_sat[i])
        );
    end

    always_comb begin
        logic ok;
        logic any_sat;
        st_d       = st_q;
        st_d.valid = in_valid;
        ok         = form_ok(in_lane, in_op);
        any_sat    = 1'b0;
        if (in_valid) begin
            st_d.data = '0;
            if (ok) begin
                case (in_lane)
                    2'(LANE_W32): begin st_d.data = w_res; any_sat = w_sat;  end
                    2'(LANE_H16): begin st_d.data = h_res; any_sat = |h_sat; end
                    2'(LANE_B8):  begin st_d.data = b_res; any_sat = |b_sat; end
                    default:      begin st_d.data = '0;    any_sat = 1'b0;   end
                endcase
            end
            st_d.ovf = st_q.ovf | any_sat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;
    assign out_ovf   = st_q.ovf;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R10
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |=> out_ovf);

    // R4
    ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_ovf) |-> $past(in_valid && in_op == 3'(SH_LEFT_S) && in_lane != 2'(LANE_B8)));

    // R9
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !form_ok(in_lane, in_op)) |=> (out_data == '0 && out_ovf == $past(out_ovf)));

endmodule

// File: tb/simd_shift_unit_tb.sv
module simd_shift_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_opnd = '0;
    logic [1:0]  in_lane = '0;
    logic [2:0]  in_op = '0;
    logic [4:0]  in_amt_imm = '0;
    logic [31:0] in_amt_reg = '0;
    logic        in_use_reg = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ovf;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit mon_on = 0;
    bit model_ovf = 0;
    logic [31:0] last_data = '0;

    logic [31:0] q_data[$];
    bit          q_ovf[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_shift_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opnd(in_opnd),
        .in_lane(in_lane), .in_op(in_op), .in_amt_imm(in_amt_imm),
        .in_amt_reg(in_amt_reg), .in_use_reg(in_use_reg),
        .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Reference model built from integer arithmetic per lane
    task automatic model(input logic [31:0] a, input logic [1:0] lm, input logic [2:0] op,
                         input logic [4:0] amt, output logic [31:0] r, output bit s);
        int n, w, am;
        bit legal;
        longint mask, v, sv, o, mx, mn;
        r = '0; s = 0;
        legal = (lm == 2'd0 || lm == 2'd1) ? (op <= 3'd3) :
                (lm == 2'd2) ? (op == 3'd0 || op == 3'd4) : 1'b0;
        if (!legal) return;
        n = (lm == 2'd0) ? 1 : (lm == 2'd1) ? 2 : 4;
        w = 32 / n;
        am = int'(amt) % w;
        mask = (64'sd1 <<< w) - 1;
        mx = (64'sd1 <<< (w - 1)) - 1;
        mn = -mx - 1;
        for (int i = 0; i < n; i++) begin
            v = (longint'(a) >>> (i * w)) & mask;
            sv = (v > mx) ? v - (mask + 1) : v;
            o = 0;
            case (op)
                3'd0: o = v <<< am;
                3'd1: begin
                    o = sv <<< am;
                    if (o > mx) begin o = mx; s = 1; end
                    else if (o < mn) begin o = mn; s = 1; end
                end
                3'd2: o = sv >>> am;
                3'd3: o = (am == 0) ? sv : ((sv + (64'sd1 <<< (am - 1))) >>> am);
                default: o = v >>> am;
            endcase
            r = r | 32'((o & mask) <<< (i * w));
        end
    endtask

    task automatic send(input logic [31:0] a, input logic [1:0] lm, input logic [2:0] op,
                        input logic [4:0] imm, input logic [31:0] rv, input bit use_reg,
                        input string tag);
        logic [31:0] er;
        bit es;
        @(negedge clk);
        in_valid = 1'b1; in_opnd = a; in_lane = lm; in_op = op;
        in_amt_imm = imm; in_amt_reg = rv; in_use_reg = use_reg;
        model(a, lm, op, use_reg ? rv[4:0] : imm, er, es);
        model_ovf = model_ovf | es;
        q_data.push_back(er);
        q_ovf.push_back(model_ovf);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_opnd = 32'hDEAD_BEEF;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (mon_on && !done) begin
            if (out_valid) begin
                if (q_data.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R1 actual=unexpected result expected=no result");
                end else begin
                    string t;
                    logic [31:0] ed;
                    bit eo;
                    t = q_tag.pop_front(); ed = q_data.pop_front(); eo = q_ovf.pop_front();
                    check(t, out_data, ed);
                    check({t, " ovf R10"}, {31'd0, out_ovf}, {31'd0, eo});
                end
                last_data = out_data;
            end else begin
                check("R1 hold", out_data, last_data);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 valid", {31'd0, out_valid}, 32'd0);
        check("R11 data", out_data, 32'd0);
        check("R11 ovf", {31'd0, out_ovf}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after release", {30'd0, out_valid, out_ovf}, 32'd0);
        mon_on = 1;

        send(32'h0000_1234, 2'd0, 3'd0, 5'd4, 32'h0, 0, "R3 word shl");
        send(32'h8001_00FF, 2'd1, 3'd0, 5'd0, 32'hFFFF_FFE4, 1, "R2 reg amount half shl");
        send(32'h8181_8181, 2'd2, 3'd0, 5'd9, 32'h0, 0, "R2 byte amount masked");
        send(32'hFFFF_FFFF, 2'd2, 3'd0, 5'd4, 32'h0, 0, "R8 byte lanes shl");
        send(32'hFFFF_FFFF, 2'd1, 3'd0, 5'd20, 32'h0, 0, "R8 half lanes shl");
        send(32'h8000_0000, 2'd0, 3'd2, 5'd31, 32'h0, 0, "R5 word sra");
        send(32'h8000_7FF0, 2'd1, 3'd2, 5'd4, 32'h0, 0, "R5 half sra");
        send(32'h0000_0005, 2'd0, 3'd3, 5'd1, 32'h0, 0, "R6 word round up");
        send(32'hFFFF_FFFB, 2'd0, 3'd3, 5'd1, 32'h0, 0, "R6 word negative round");
        send(32'h7FFF_8000, 2'd1, 3'd3, 5'd15, 32'h0, 0, "R6 half extra bit");
        send(32'h1234_ABCD, 2'd1, 3'd3, 5'd0, 32'h0, 0, "R6 zero amount");
        send(32'h80F0_1F01, 2'd2, 3'd4, 5'd3, 32'h0, 0, "R7 byte srl");
        send(32'h0001_FFFF, 2'd1, 3'd1, 5'd3, 32'h0, 0, "R4 half sat no clamp");
        send(32'h1234_5678, 2'd2, 3'd2, 5'd1, 32'h0, 0, "R9 byte sra illegal");
        send(32'h1234_5678, 2'd0, 3'd4, 5'd1, 32'h0, 0, "R9 word srl illegal");
        send(32'h1234_5678, 2'd3, 3'd0, 5'd1, 32'h0, 0, "R9 lane 3 illegal");
        send(32'h4000_0000, 2'd2, 3'd1, 5'd2, 32'h0, 0, "R9 byte sat shl illegal");
        send(32'h1234_5678, 2'd0, 3'd7, 5'd1, 32'h0, 0, "R9 op 7 illegal");
        idle(2);
        send(32'h4000_0000, 2'd0, 3'd1, 5'd1, 32'h0, 0, "R4 word sat max");
        send(32'h8000_4000, 2'd1, 3'd1, 5'd2, 32'h0, 0, "R4 half sat both");
        idle(1);
        send(32'h0000_0001, 2'd0, 3'd0, 5'd1, 32'h0, 0, "R10 sticky kept");

        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 4));
            send($urandom, 2'($urandom_range(0, 2)), op, 5'($urandom), $urandom,
                 bit'($urandom & 1), (op == 3'd1) ? "R4 random" :
                 (op == 3'd3) ? "R6 random" : (op == 3'd4) ? "R7 random" : "R3 random");
            if ((i % 37) == 0) idle(1);
        end
        idle(3);
        checks++;
        if (q_data.size() != 0) begin
            failures++;
            $display("FAIL R1 actual=%0d pending expected=0", q_data.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule